// File: doc/BRIEF.md
# Temperature Threshold Monitor with Latched Alarms

This block watches a stream of filtered 12-bit temperature codes from one sensor. It compares every valid code against five programmable limits: an upper trip, a lower trip, a hot limit, a normal-to-hot limit and a cold limit. Each crossing sets a latched status flag. The flags stay set until software clears them by writing ones. An enable mask with the same bit layout selects which flags drive a single level-sensitive interrupt line.

Configuration goes through a simple write port: a strobe, a 3-bit register select and a data word. The hot alarm uses the higher of the hot limit and the normal-to-hot limit. When it fires, it raises two flags together. Until the normal-to-hot limit has been written for the first time, the cold limit stands in for it.

Register select codes are: 0 upper trip, 1 lower trip, 2 hot limit, 3 normal-to-hot limit, 4 cold limit, 5 interrupt enable, 6 write-one-to-clear of the status flags. Codes 5 and 6 use data bits [5:0]. Status bit positions are: 0 hot, 1 cold, 2 upper trip, 3 lower trip, 4 unused, 5 normal-to-hot.

Top module: `thmon_top`

## Requirements
- R1: After reset, all status flags read 0 and the interrupt is low. The limits reset to: upper trip 0xFFF, hot 0xFFF, lower trip 0, cold 0, enable 0.
- R2: A valid code strictly greater than the upper trip limit sets status bit 2. A code equal to the limit does not.
- R3: A valid code strictly less than the lower trip limit sets status bit 3. A code equal to the limit does not.
- R4: A valid code strictly less than the cold limit sets status bit 1.
- R5: A valid code strictly greater than the larger of the hot limit and the effective normal-to-hot limit sets status bits 0 and 5 in the same cycle. A code above only the smaller of the two sets neither bit.
- R6: Until select code 3 has been written after reset, the cold limit is used as the normal-to-hot limit.
- R7: Status flags are sticky. A later in-range code, or any code presented without sample_valid, leaves them unchanged.
- R8: A write to select code 6 clears exactly the status flags whose data bits are 1. Status updates on the clock edge that registers a sample or a write.
- R9: When a flag's set event and its clear arrive in the same cycle, the flag ends up set. Other flags named in that clear still clear.
- R10: irq_o is high exactly when some status flag and the enable bit at the same position are both 1. It follows enable writes and clears from the next edge.
- R11: Status bit 4 is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | sample_code carries a new filtered reading |
| sample_code | input | 12 | Filtered temperature code |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select code |
| wr_data | input | 12 | Write data |
| status_o | output | 6 | Latched alarm flags |
| irq_o | output | 1 | Level interrupt |

## Verification
Each limit is tested with a code exactly at the limit and a code one step past it. This separates strict from inclusive comparison. The hot alarm is tested in three setups: the hot limit below the cold stand-in, below a written normal-to-hot value, and above it. This shows whether the larger limit is chosen and whether the stand-in stops applying once the register is written. Clears are tested alone, partially, and in the same cycle as a setting sample. The last case separates set-priority from clear-priority.

// File: rtl/thmon_pkg.sv
package thmon_pkg;

    localparam int ST_W = 6;

    localparam int B_HOT  = 0;
    localparam int B_COLD = 1;
    localparam int B_UPR  = 2;
    localparam int B_LWR  = 3;
    localparam int B_RSV  = 4;
    localparam int B_N2H  = 5;

    typedef enum logic [2:0] {
        SEL_UPR  = 3'd0,
        SEL_LWR  = 3'd1,
        SEL_HOT  = 3'd2,
        SEL_N2H  = 3'd3,
        SEL_COLD = 3'd4,
        SEL_IEN  = 3'd5,
        SEL_CLR  = 3'd6
    } sel_e;

    localparam logic [ST_W-1:0] ST_USED = ST_W'(6'b101111);

endpackage

// File: rtl/thmon_cfg.sv
module thmon_cfg
    import thmon_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [CODE_W-1:0] wr_data,
    output logic [CODE_W-1:0] upr_lim,
    output logic [CODE_W-1:0] lwr_lim,
    output logic [CODE_W-1:0] hot_lim,
    output logic [CODE_W-1:0] n2h_eff,
    output logic [CODE_W-1:0] cold_lim,
    output logic [ST_W-1:0]   ien
);

    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    typedef struct packed {
        logic [CODE_W-1:0] upr;
        logic [CODE_W-1:0] lwr;
        logic [CODE_W-1:0] hot;
        logic [CODE_W-1:0] n2h;
        logic [CODE_W-1:0] cold;
        logic              n2h_set;
        logic [ST_W-1:0]   ien;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (sel_e'(wr_addr))
                SEL_UPR:  cfg_d.upr  = wr_data;
                SEL_LWR:  cfg_d.lwr  = wr_data;
                SEL_HOT:  cfg_d.hot  = wr_data;
                SEL_N2H: begin
                    cfg_d.n2h     = wr_data;
                    cfg_d.n2h_set = 1'b1;
                end
                SEL_COLD: cfg_d.cold = wr_data;
                SEL_IEN:  cfg_d.ien  = wr_data[ST_W-1:0] & ST_USED;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.upr     <= CODE_MAX;
            cfg_q.lwr     <= '0;
            cfg_q.hot     <= CODE_MAX;
            cfg_q.n2h     <= '0;
            cfg_q.cold    <= '0;
            cfg_q.n2h_set <= 1'b0;
            cfg_q.ien     <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign upr_lim  = cfg_q.upr;
    assign lwr_lim  = cfg_q.lwr;
    assign hot_lim  = cfg_q.hot;
    assign n2h_eff  = cfg_q.n2h_set ? cfg_q.n2h : cfg_q.cold;
    assign cold_lim = cfg_q.cold;
    assign ien      = cfg_q.ien;

endmodule

// File: rtl/thmon_cmp.sv
module thmon_cmp
    import thmon_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic [CODE_W-1:0] code,
    input  logic [CODE_W-1:0] upr_lim,
    input  logic [CODE_W-1:0] lwr_lim,
    input  logic [CODE_W-1:0] hot_lim,
    input  logic [CODE_W-1:0] n2h_eff,
    input  logic [CODE_W-1:0] cold_lim,
    output logic [ST_W-1:0]   hits
);

    logic [CODE_W-1:0] hot_lvl;
    logic              hot_hit;

    always_comb begin
        hot_lvl = (hot_lim > n2h_eff) ? hot_lim : n2h_eff;
        hot_hit = code > hot_lvl;
        hits          = '0;
        hits[B_HOT]   = hot_hit;
        hits[B_N2H]   = hot_hit;
        hits[B_COLD]  = code < cold_lim;
        hits[B_UPR]   = code > upr_lim;
        hits[B_LWR]   = code < lwr_lim;
        hits[B_RSV]   = 1'b0;
    end

endmodule

// File: rtl/thmon_top.sv
module thmon_top
    import thmon_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic [CODE_W-1:0] sample_code,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [CODE_W-1:0] wr_data,
    output logic [ST_W-1:0]   status_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [ST_W-1:0] status;
    } st_t;

    st_t st_d, st_q;

    logic [CODE_W-1:0] upr_lim, lwr_lim, hot_lim, n2h_eff, cold_lim;
    logic [ST_W-1:0]   ien, hits, set_v, clr_v;

    thmon_cfg #(.CODE_W(CODE_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .upr_lim  (upr_lim),
        .lwr_lim  (lwr_lim),
        .hot_lim  (hot_lim),
        .n2h_eff  (n2h_eff),
        .cold_lim (cold_lim),
        .ien      (ien)
    );

    thmon_cmp #(.CODE_W(CODE_W)) u_cmp (
        .code     (sample_code),
        .upr_lim  (upr_lim),
        .lwr_lim  (lwr_lim),
        .hot_lim  (hot_lim),
        .n2h_eff  (n2h_eff),
        .cold_lim (cold_lim),
        .hits     (hits)
    );

    always_comb begin
        set_v = sample_valid ? hits : '0;
        clr_v = (wr_en && sel_e'(wr_addr) == SEL_CLR) ? wr_data[ST_W-1:0] : '0;
        st_d.status = ((st_q.status & ~clr_v) | set_v) & ST_USED;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.status;
    assign irq_o    = |(st_q.status & ien);

endmodule

// File: rtl/thmon_chk.sv
module thmon_chk
    import thmon_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sample_valid,
    input logic              wr_en,
    input logic [2:0]        wr_addr,
    input logic [CODE_W-1:0] wr_data,
    input logic [ST_W-1:0]   status_o,
    input logic              irq_o
);

    logic clr_wr;
    assign clr_wr = wr_en && (wr_addr == 3'd6);

    always @(negedge clk) begin
        if (rst_n === 1'b0) begin
            p_reset_clear_r1: assert (status_o == '0 && irq_o == 1'b0)
                else $error("status or irq not cleared in reset");
        end
    end

    p_upr_needs_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[B_UPR]) |-> $past(sample_valid));

    p_hot_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[B_HOT]) |-> status_o[B_N2H]);

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((status_o & $past(status_o)) == $past(status_o)));

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !sample_valid) |=> ((status_o & $past(wr_data[ST_W-1:0])) == '0));

    p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !wr_en) |=> irq_o);

    p_rsv_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[B_RSV]);

endmodule

bind thmon_top thmon_chk #(.CODE_W(CODE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_valid (sample_valid),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .status_o     (status_o),
    .irq_o        (irq_o)
);

// File: tb/tb_thmon_top.sv
module tb_thmon_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_valid = 1'b0;
    logic [11:0] sample_code = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic [5:0]  status_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    thmon_top dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (sample_valid),
        .sample_code  (sample_code),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .status_o     (status_o),
        .irq_o        (irq_o)
    );

    task automatic chk(input logic [11:0] act, input logic [11:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [11:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic smp(input logic [11:0] c);
        sample_valid = 1'b1; sample_code = c;
        @(posedge clk); @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk({6'd0, status_o}, 12'h000, "R1 status after reset");
        chk({11'd0, irq_o}, 12'h000, "R1 irq after reset");
    endtask

    task automatic t_upper();
        wr(3'd0, 12'h800);
        smp(12'h800);
        chk({6'd0, status_o}, 12'h000, "R2 equal to upper trip");
        smp(12'h801);
        chk({6'd0, status_o}, 12'h004, "R2 above upper trip");
        wr(3'd6, 12'h03F);
        chk({6'd0, status_o}, 12'h000, "R8 clear all");
    endtask

    task automatic t_lower();
        wr(3'd1, 12'h100);
        smp(12'h100);
        chk({6'd0, status_o}, 12'h000, "R3 equal to lower trip");
        smp(12'h0FF);
        chk({6'd0, status_o}, 12'h008, "R3 below lower trip");
        wr(3'd6, 12'h03F);
    endtask

    task automatic t_cold();
        wr(3'd4, 12'h200);
        smp(12'h150);
        chk({6'd0, status_o}, 12'h002, "R4 below cold");
        wr(3'd6, 12'h03F);
    endtask

    task automatic t_fallback();
        wr(3'd2, 12'h100);
        smp(12'h180);
        chk({6'd0, status_o}, 12'h002, "R6 above hot but not cold stand-in");
        smp(12'h201);
        chk({6'd0, status_o}, 12'h023, "R6 above cold stand-in sets hot pair");
        wr(3'd6, 12'h03F);
    endtask

    task automatic t_hot();
        wr(3'd3, 12'h300);
        smp(12'h250);
        chk({6'd0, status_o}, 12'h000, "R6 written n2h replaces stand-in");
        smp(12'h301);
        chk({6'd0, status_o}, 12'h021, "R5 above n2h limit");
        wr(3'd6, 12'h03F);
        wr(3'd2, 12'h400);
        smp(12'h350);
        chk({6'd0, status_o}, 12'h000, "R5 above smaller limit only");
        smp(12'h401);
        chk({6'd0, status_o}, 12'h021, "R5 above hot limit");
        wr(3'd6, 12'h03F);
    endtask

    task automatic t_sticky();
        smp(12'hF00);
        chk({6'd0, status_o}, 12'h025, "R7 hot and upper set");
        smp(12'h280);
        chk({6'd0, status_o}, 12'h025, "R7 in-range sample keeps flags");
        sample_code = 12'h000;
        @(posedge clk); @(negedge clk);
        chk({6'd0, status_o}, 12'h025, "R7 code without valid ignored");
        chk({11'd0, status_o[4]}, 12'h000, "R11 bit 4 never set");
    endtask

    task automatic t_w1c();
        wr(3'd6, 12'h004);
        chk({6'd0, status_o}, 12'h021, "R8 partial clear");
        wr(3'd6, 12'h021);
        chk({6'd0, status_o}, 12'h000, "R8 clear remaining");
    endtask

    task automatic t_set_wins();
        smp(12'h050);
        chk({6'd0, status_o}, 12'h00A, "R9 setup cold and lower");
        sample_valid = 1'b1; sample_code = 12'h900;
        wr_en = 1'b1; wr_addr = 3'd6; wr_data = 12'h03F;
        @(posedge clk); @(negedge clk);
        sample_valid = 1'b0; wr_en = 1'b0;
        chk({6'd0, status_o}, 12'h025, "R9 set beats simultaneous clear");
    endtask

    task automatic t_irq();
        chk({11'd0, irq_o}, 12'h000, "R10 irq low with enable zero");
        wr(3'd5, 12'h002);
        chk({11'd0, irq_o}, 12'h000, "R10 enabled bit not set");
        wr(3'd5, 12'h004);
        chk({11'd0, irq_o}, 12'h001, "R10 enabled bit set");
        @(negedge clk);
        chk({11'd0, irq_o}, 12'h001, "R10 irq level held");
        wr(3'd6, 12'h004);
        chk({11'd0, irq_o}, 12'h000, "R10 irq drops after clear");
        chk({6'd0, status_o}, 12'h021, "R8 other flags kept");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_upper();
        t_lower();
        t_cold();
        t_fallback();
        t_hot();
        t_sticky();
        t_w1c();
        t_set_wins();
        t_irq();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule